// File: doc/BRIEF.md
# Periodic Wake-up Interval Timer

This block raises an interrupt pulse at a fixed interval for a system that sleeps between events. It runs from a slow reference clock, 32.768 kHz by default. Its only control inputs are an active-low reset pin and two interval-select pins. Four parameters hold the cycle counts of the four intervals. By default these are 1 s, 2 s, 4 s and 8 s.

The reset pin passes through a debounce filter before the timer may run. The pin must read high for a parameterised number of consecutive cycles, 0.5 s by default, before the filter releases. A single low sample clears the filter and stops the timer on the next clock. On release, the block captures the select pins and starts counting from zero. When the count reaches the chosen interval, the block clears the count, emits one pulse of parameterised width and keeps counting. It repeats this until the reset pin goes low again. A parameter chooses the polarity of the interrupt line. The default line is high when idle and pulses low.

Top module: `wake_timer`

## Requirements
- R1: On any clock edge that samples `rst_pin_n` low, the timer stops and clears its count. From the next cycle on, `int_out` is at its inactive level: high when ACTIVE_HIGH=0, low when ACTIVE_HIGH=1.
- R2: The timer releases only after `rst_pin_n` has been sampled high on DEBOUNCE_CYCLES consecutive edges. A low sample restarts this count.
- R3: The select pins are captured on the edge that releases the timer. Later changes on `sel` do not change the interval until the next release.
- R4: The interval follows the captured select code: 2'b00 gives IVL0 cycles, 2'b01 gives IVL1, 2'b10 gives IVL2 and 2'b11 gives IVL3. The pin may rise just after a clock edge. In that case the first pulse shows on `int_out` right after edge DEBOUNCE_CYCLES + interval, counted from that rise.
- R5: Each pulse starts on the cycle after the match and lasts exactly PULSE_CYCLES cycles.
- R6: After each match the count restarts from zero. Consecutive pulses start exactly one interval apart for as long as the reset pin stays high.
- R7: With ACTIVE_HIGH=0 the pulse is low on a high idle line. With ACTIVE_HIGH=1 the line is exactly inverted.
- R8: A reset during counting, before a match, discards the partial count. After the next release, the first pulse again takes a full debounce plus a full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst_pin_n | input | 1 | Active-low reset pin, debounced inside the block |
| sel | input | 2 | Interval select code, captured at release |
| int_out | output | 1 | Periodic interrupt pulse, polarity set by ACTIVE_HIGH |

## Verification
The hardest situation to reach is a select change while the timer is counting that must have no effect. It needs a release with one code, a different code applied mid-count, and then an observed period. The stimulus changes `sel` between pulses in every run and measures pulse-to-pulse spacing against the captured code. Short bounces on the reset pin test the filter restart. A reset pulse placed just before a match checks that the partial count is discarded. The bench shrinks the debounce and interval parameters so that each of these fits in a few hundred cycles.

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int unsigned DEBOUNCE_CYCLES = 16384,
  parameter int unsigned PULSE_CYCLES    = 256,
  parameter int unsigned IVL0            = 32768,
  parameter int unsigned IVL1            = 65536,
  parameter int unsigned IVL2            = 131072,
  parameter int unsigned IVL3            = 262144,
  parameter bit          ACTIVE_HIGH     = 1'b0
) (
  input  logic       clk,
  input  logic       rst_pin_n,
  input  logic [1:0] sel,
  output logic       int_out
);

  localparam int unsigned IMAX01 = (IVL0 > IVL1) ? IVL0 : IVL1;
  localparam int unsigned IMAX23 = (IVL2 > IVL3) ? IVL2 : IVL3;
  localparam int unsigned IMAX   = (IMAX01 > IMAX23) ? IMAX01 : IMAX23;
  localparam int CW = $clog2(IMAX + 1);
  localparam int DW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [DW-1:0] db_cnt;
  logic          run;
  logic [1:0]    sel_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ival;
  logic [PW-1:0] pcnt;
  logic          act;
  logic          match;

  always_comb begin
    case (sel_q)
      2'b00:   ival = CW'(IVL0);
      2'b01:   ival = CW'(IVL1);
      2'b10:   ival = CW'(IVL2);
      default: ival = CW'(IVL3);
    endcase
  end

  wire db_done = (db_cnt == DW'(DEBOUNCE_CYCLES - 1));
  assign match = run && (cnt == ival - CW'(1));
  assign act   = (pcnt != '0);
  assign int_out = ACTIVE_HIGH ? act : ~act;

  always_ff @(posedge clk) begin
    if (!rst_pin_n) begin
      db_cnt <= '0;
      run    <= 1'b0;
      sel_q  <= 2'b00;
    end else if (!run) begin
      if (db_done) begin
        run   <= 1'b1;
        sel_q <= sel;
      end else begin
        db_cnt <= db_cnt + DW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_pin_n || !run) begin
      cnt  <= '0;
      pcnt <= '0;
    end else if (match) begin
      cnt  <= '0;
      pcnt <= PW'(PULSE_CYCLES);
    end else begin
      cnt <= cnt + CW'(1);
      if (act) pcnt <= pcnt - PW'(1);
    end
  end

endmodule

// File: rtl/wake_timer_chk.sv
module wake_timer_chk #(
  parameter int unsigned PULSE_CYCLES = 256,
  parameter int CW = 8,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_pin_n,
  input logic [1:0]    sel_q,
  input logic          run,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] ival,
  input logic [PW-1:0] pcnt,
  input logic          act
);

  p_quiet_after_low_r1: assert property (@(posedge clk)
    !rst_pin_n |=> (!act && cnt == '0 && !run));

  p_release_needs_high_r2: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(run) |-> $past(rst_pin_n));

  p_sel_frozen_r3: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (run && $past(run)) |-> $stable(sel_q));

  p_count_in_range_r6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    run |-> (cnt < ival));

  p_pulse_after_match_r5: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(act) |-> ($past(cnt) == ival - CW'(1) && pcnt == PW'(PULSE_CYCLES)));

  p_pulse_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_pin_n)
    pcnt <= PW'(PULSE_CYCLES));

endmodule

bind wake_timer wake_timer_chk #(
  .PULSE_CYCLES(PULSE_CYCLES),
  .CW(CW),
  .PW(PW)
) u_chk (
  .clk(clk),
  .rst_pin_n(rst_pin_n),
  .sel_q(sel_q),
  .run(run),
  .cnt(cnt),
  .ival(ival),
  .pcnt(pcnt),
  .act(act)
);

// File: tb/wake_timer_test.sv
`timescale 1ns/1ps
module wake_timer_test;
  localparam int DEB = 6;
  localparam int PUL = 3;
  localparam int I0 = 10, I1 = 14, I2 = 20, I3 = 27;

  logic clk = 1'b0;
  logic pin_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic int_lo, int_hi;

  always #2 clk = ~clk;

  wake_timer #(.DEBOUNCE_CYCLES(DEB), .PULSE_CYCLES(PUL), .IVL0(I0), .IVL1(I1),
               .IVL2(I2), .IVL3(I3), .ACTIVE_HIGH(1'b0))
    uut (.clk(clk), .rst_pin_n(pin_n), .sel(sel), .int_out(int_lo));

  wake_timer #(.DEBOUNCE_CYCLES(DEB), .PULSE_CYCLES(PUL), .IVL0(I0), .IVL1(I1),
               .IVL2(I2), .IVL3(I3), .ACTIVE_HIGH(1'b1))
    uut_hi (.clk(clk), .rst_pin_n(pin_n), .sel(sel), .int_out(int_hi));

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  int m_hi = 0, m_cnt = 0, m_pl = 0, m_sel = 0;
  bit m_run = 0;
  bit compare_on = 0;

  function automatic int ivl_of(int s);
    case (s)
      0: return I0;
      1: return I1;
      2: return I2;
      default: return I3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!pin_n) begin
      m_hi = 0; m_run = 0; m_cnt = 0; m_pl = 0;
    end else if (!m_run) begin
      m_cnt = 0; m_pl = 0;
      if (m_hi == DEB - 1) begin m_run = 1; m_sel = int'(sel); end
      else m_hi++;
    end else if (m_cnt == ivl_of(m_sel) - 1) begin
      m_cnt = 0; m_pl = PUL;
    end else begin
      m_cnt++;
      if (m_pl > 0) m_pl--;
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      checks++;
      if (int_lo !== (m_pl == 0)) begin
        errors++;
        $display("FAIL %s low-active line: actual %b expected %b", phase, int_lo, (m_pl == 0));
      end
      checks++;
      if (int_hi !== (m_pl != 0)) begin
        errors++;
        $display("FAIL R7 high-active line: actual %b expected %b", int_hi, (m_pl != 0));
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_active(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (int_lo !== 1'b0 && n < 1000);
  endtask

  task automatic run_code(input logic [1:0] code, input logic [1:0] other);
    int n, w, p;
    pin_n = 1'b0; sel = code;
    repeat (3) @(negedge clk);
    phase = "R4";
    pin_n = 1'b1;
    wait_active(n);
    check("R4 first pulse delay", n, DEB + ivl_of(int'(code)));
    phase = "R5";
    w = 0;
    while (int_lo === 1'b0 && w < 100) begin @(negedge clk); w++; end
    check("R5 pulse width", w, PUL);
    phase = "R3";
    sel = other;
    wait_active(p);
    check("R6 period under changed sel (R3)", p + w, ivl_of(int'(code)));
    phase = "R6";
    repeat (2 * ivl_of(int'(code))) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    compare_on = 1;
    phase = "R1";
    check("R1 idle level low-active", int'(int_lo), 1);
    check("R7 idle level high-active", int'(int_hi), 0);

    phase = "R2";
    sel = 2'b01;
    pin_n = 1'b1; repeat (DEB - 1) @(negedge clk);
    pin_n = 1'b0; @(negedge clk);
    pin_n = 1'b1; repeat (DEB - 2) @(negedge clk);
    pin_n = 1'b0; @(negedge clk);
    pin_n = 1'b1;
    wait_active(n);
    check("R2 bounce restarts filter", n, DEB + I1);
    repeat (2 * I1) @(negedge clk);

    run_code(2'b00, 2'b11);
    run_code(2'b01, 2'b00);
    run_code(2'b10, 2'b01);
    run_code(2'b11, 2'b10);

    phase = "R8";
    pin_n = 1'b0; sel = 2'b00; repeat (2) @(negedge clk);
    pin_n = 1'b1; repeat (DEB + I0 - 2) @(negedge clk);
    pin_n = 1'b0; @(negedge clk);
    check("R1 inactive after reset", int'(int_lo), 1);
    pin_n = 1'b1;
    wait_active(n);
    check("R8 full delay after mid-count reset", n, DEB + I0);
    repeat (3 * I0) @(negedge clk);

    phase = "R1";
    pin_n = 1'b0; @(negedge clk);
    check("R1 inactive after reset low-active", int'(int_lo), 1);
    check("R1 inactive after reset high-active", int'(int_hi), 0);
    repeat (I3 + 5) @(negedge clk);
    check("R1 stays inactive", int'(int_lo), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule